// File: doc/BRIEF.md
# Multiplexed Four-Digit Display Scanner

This block drives a four-digit seven-segment LED array whose digits share one set of segment lines. Because every digit sees the same segment wires, only one digit can be lit at a time. The scanner lights the digits in turn and holds each one for about a millisecond. At that rate the eye sees all four digits lit together.

The block takes four 4-bit hexadecimal values and four decimal-point bits. It turns the selected value into a segment pattern and drives that pattern on an 8-bit segment bus. It also drives a 4-bit common-line bus. A prescaler counts clock cycles and sets the dwell time, so only the `CLK_HZ` parameter needs to change between clock domains. The scan state machine has five states:

- `ST_BLANK`: entered on reset; no digit is selected.
- `ST_DIG0` to `ST_DIG3`: one state per lit digit.

Its transitions are:

- RESET: any state to `ST_BLANK` while `rst` is high.
- ENTER: `ST_BLANK` to `ST_DIG0` on the first clock after reset is released.
- ADVANCE: `ST_DIGk` to `ST_DIGk+1` on a prescaler tick.
- WRAP: `ST_DIG3` to `ST_DIG0` on a prescaler tick.

The segment pattern register loads on ENTER, ADVANCE and WRAP. It is cleared on RESET.

Top module: `disp_scan_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, from that edge onward `dig_sel_n` is 4'b1111 and `seg_out` is 8'h00. Reset takes priority over a prescaler tick in the same cycle.
- R2: Outside reset, at most one bit of `dig_sel_n` is 0. The selected digit k has `dig_sel_n[k]` driven 0 and every other bit driven 1.
- R3: Each digit stays selected for exactly DIV = CLK_HZ/SCAN_HZ clock cycles. With the defaults this is 1 ms.
- R4: Digits are selected in the order 0, 1, 2, 3 and then back to 0. Digit 0 is the leftmost digit and corresponds to `dig_sel_n[0]`.
- R5: `seg_out[6:0]` holds segments G..A, and a 1 lights a segment. In hex the codes are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=27, 8=7F, 9=6F, A=77, b=7C, c=58, d=5E, E=79, F=71. Digit k's value is `digit_val[4k+3:4k]`.
- R6: `seg_out[7]` is the decimal point and equals `digit_dp[k]` of the selected digit k.
- R7: A digit's value and decimal point are captured at the edge where that digit becomes selected, including a value that changes in the cycle just before that edge. Later input changes have no effect on `seg_out` until the next digit change.
- R8: On the first rising edge after reset is released, digit 0 becomes selected, showing its pattern. `dig_sel_n` and `seg_out` change on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_val | input | 16 | Four hex digits; digit k in bits 4k+3:4k |
| digit_dp | input | 4 | Decimal point per digit; bit k for digit k |
| seg_out | output | 8 | Segment bus: dp,G,F,E,D,C,B,A from MSB to LSB, 1 = lit |
| dig_sel_n | output | 4 | Digit common lines, active low, bit k for digit k |

## Verification
Two events can fall on one edge: the prescaler tick that advances the scan, and either a synchronous reset or a change to the digit inputs.

- Reset on a tick: the bench locates the last cycle of a dwell by counting cycles from the observed digit change. It raises reset in exactly that cycle and expects the blank state, not the next digit.
- Input change on a tick: in that same last cycle, the bench writes a new value into the digit about to be selected. It expects the new pattern on the following edge.
- Input change mid-dwell: changing the digit currently shown, in the middle of its dwell, must leave `seg_out` unchanged.

// File: rtl/disp_scan_pkg.sv
package disp_scan_pkg;

    localparam int NUM_DIG = 4;
    localparam int IDX_W   = $clog2(NUM_DIG);

    typedef enum logic [2:0] {
        ST_BLANK,
        ST_DIG0,
        ST_DIG1,
        ST_DIG2,
        ST_DIG3
    } scan_state_t;

    // segment code for one hex nibble, bit 6..0 = G..A, 1 = lit
    function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
        logic [6:0] s;
        unique case (nib)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h27;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h77;
            4'hB: s = 7'h7C;
            4'hC: s = 7'h58;
            4'hD: s = 7'h5E;
            4'hE: s = 7'h79;
            default: s = 7'h71;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp_scan_prescaler.sv
module disp_scan_prescaler #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCAN_HZ = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int DIV = CLK_HZ / SCAN_HZ;
    localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // counter stays at zero until the scan is running, so every dwell is DIV cycles
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/disp_scan_fsm.sv
module disp_scan_fsm
    import disp_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic             run,
    output logic             load,
    output logic [IDX_W-1:0] load_idx,
    output logic [3:0]       sel_n
);
    scan_state_t state_q;
    scan_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BLANK;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ENTER, ADVANCE, WRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BLANK: state_d = ST_DIG0;
            ST_DIG0:  if (tick) state_d = ST_DIG1;
            ST_DIG1:  if (tick) state_d = ST_DIG2;
            ST_DIG2:  if (tick) state_d = ST_DIG3;
            ST_DIG3:  if (tick) state_d = ST_DIG0;
            default:  state_d = ST_BLANK;
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        run      = 1'b1;
        load     = tick;
        load_idx = '0;
        sel_n    = 4'b1111;
        unique case (state_q)
            ST_BLANK: begin
                run      = 1'b0;
                load     = 1'b1;
                load_idx = IDX_W'(0);
                sel_n    = 4'b1111;
            end
            ST_DIG0: begin
                load_idx = IDX_W'(1);
                sel_n    = 4'b1110;
            end
            ST_DIG1: begin
                load_idx = IDX_W'(2);
                sel_n    = 4'b1101;
            end
            ST_DIG2: begin
                load_idx = IDX_W'(3);
                sel_n    = 4'b1011;
            end
            ST_DIG3: begin
                load_idx = IDX_W'(0);
                sel_n    = 4'b0111;
            end
            default: begin
                run   = 1'b0;
                load  = 1'b0;
                sel_n = 4'b1111;
            end
        endcase
    end

endmodule

// File: rtl/disp_scan_decode.sv
module disp_scan_decode
    import disp_scan_pkg::*;
(
    input  logic [4*NUM_DIG-1:0] digit_val,
    input  logic [NUM_DIG-1:0]   digit_dp,
    input  logic [IDX_W-1:0]     idx,
    output logic [7:0]           pattern
);
    logic [7:0] pat [NUM_DIG];

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        assign pat[g] = {digit_dp[g], hex_to_seg(digit_val[4*g +: 4])};
    end

    assign pattern = pat[idx];

endmodule

// File: rtl/disp_scan_top.sv
module disp_scan_top
    import disp_scan_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int SCAN_HZ = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] digit_val,
    input  logic [3:0]  digit_dp,
    output logic [7:0]  seg_out,
    output logic [3:0]  dig_sel_n
);
    localparam int DIV = CLK_HZ / SCAN_HZ;

    logic             scan_tick;
    logic             scan_run;
    logic             pat_load;
    logic [IDX_W-1:0] pat_idx;
    logic [7:0]       pat_next;
    logic [7:0]       seg_q;

    disp_scan_prescaler #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (scan_run),
        .tick (scan_tick)
    );

    disp_scan_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (scan_tick),
        .run      (scan_run),
        .load     (pat_load),
        .load_idx (pat_idx),
        .sel_n    (dig_sel_n)
    );

    disp_scan_decode u_dec (
        .digit_val (digit_val),
        .digit_dp  (digit_dp),
        .idx       (pat_idx),
        .pattern   (pat_next)
    );

    // pattern captured on the same edge that changes the state
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= 8'h00;
        end else if (pat_load) begin
            seg_q <= pat_next;
        end
    end

    assign seg_out = seg_q;

endmodule

// File: rtl/disp_scan_chk.sv
module disp_scan_chk #(
    parameter int DIV = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [3:0] sel_n,
    input logic [7:0] seg
);
    localparam int GW = $clog2(DIV) + 1;

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || tick || sel_n == 4'hF) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    a_r1_reset_blank: assert property (@(posedge clk)
        rst |=> (sel_n == 4'hF && seg == 8'h00));

    // R2
    a_r2_single_digit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sel_n));

    // R3
    a_r3_dwell: assert property (@(posedge clk) disable iff (rst)
        tick |-> gap_q == GW'(DIV - 1));

    // R4
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        (tick && sel_n != 4'hF) |=> sel_n == {$past(sel_n[2:0]), $past(sel_n[3])});

    // R7
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && sel_n != 4'hF) |=> ($stable(seg) && $stable(sel_n)));

    // R8
    a_r8_enter_first: assert property (@(posedge clk) disable iff (rst)
        (sel_n == 4'hF) |=> sel_n == 4'b1110);

endmodule

bind disp_scan_top disp_scan_chk #(.DIV(DIV)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (scan_tick),
    .sel_n (dig_sel_n),
    .seg   (seg_out)
);

// File: tb/sim_disp_scan_top.sv
module sim_disp_scan_top;

    localparam int CLK_HZ  = 8000;
    localparam int SCAN_HZ = 1000;
    localparam int DIV     = CLK_HZ / SCAN_HZ;

    // {value, dp, expected G..A}
    localparam logic [11:0] VEC [16] = '{
        {4'h0, 1'b0, 7'h3F}, {4'h1, 1'b1, 7'h06}, {4'h2, 1'b0, 7'h5B}, {4'h3, 1'b1, 7'h4F},
        {4'h4, 1'b0, 7'h66}, {4'h5, 1'b1, 7'h6D}, {4'h6, 1'b0, 7'h7D}, {4'h7, 1'b1, 7'h27},
        {4'h8, 1'b0, 7'h7F}, {4'h9, 1'b1, 7'h6F}, {4'hA, 1'b0, 7'h77}, {4'hB, 1'b1, 7'h7C},
        {4'hC, 1'b0, 7'h58}, {4'hD, 1'b1, 7'h5E}, {4'hE, 1'b0, 7'h79}, {4'hF, 1'b1, 7'h71}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dv  = 16'h0000;
    logic [3:0]  dp  = 4'h0;
    logic [7:0]  seg_out;
    logic [3:0]  dig_sel_n;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    disp_scan_top #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ)) u0 (
        .clk       (clk),
        .rst       (rst),
        .digit_val (dv),
        .digit_dp  (dp),
        .seg_out   (seg_out),
        .dig_sel_n (dig_sel_n)
    );

    function automatic logic [7:0] exp_seg(input logic [3:0] v, input logic p);
        return {p, VEC[v][6:0]};
    endfunction

    function automatic logic [3:0] sel_of(input int k);
        return 4'(~(4'b0001 << k));
    endfunction

    function automatic int idx_of(input logic [3:0] s);
        for (int k = 0; k < 4; k++) if (s == sel_of(k)) return k;
        return -1;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_digit(input int k, input logic [3:0] v, input logic p);
        dv[4*k +: 4] = v;
        dp[k]        = p;
    endtask

    task automatic wait_for(input int k);
        int n = 0;
        while (dig_sel_n !== sel_of(k) && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (n >= 100) check("R4 wait", {12'h0, dig_sel_n}, {12'h0, sel_of(k)});
    endtask

    task automatic wait_change();
        logic [3:0] prev = dig_sel_n;
        int n = 0;
        while (dig_sel_n === prev && n < 100) begin
            @(negedge clk);
            n++;
        end
        if (n >= 100) check("R3 stall", {12'h0, dig_sel_n}, 16'hFFFF);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 sel in reset", {12'h0, dig_sel_n}, 16'h000F);
        check("R1 seg in reset", {8'h0, seg_out}, 16'h0000);

        // R8: first digit one cycle after release
        dv = 16'h0000;
        dp = 4'b0000;
        rst = 1'b0;
        @(negedge clk);
        check("R8 first digit sel", {12'h0, dig_sel_n}, 16'h000E);
        check("R8 first digit seg", {8'h0, seg_out}, {8'h0, exp_seg(4'h0, 1'b0)});

        // R5/R6: vector walk, one table entry per digit entry
        for (int i = 0; i < 16; i++) begin
            int k = i % 4;
            wait_for((k + 3) % 4);
            set_digit(k, VEC[i][11:8], VEC[i][7]);
            wait_for(k);
            check($sformatf("R5/R6 hex %0h digit %0d", i, k), {8'h0, seg_out},
                  {8'h0, VEC[i][7], VEC[i][6:0]});
        end

        // R3 + R2: dwell length and single active common
        begin
            logic [3:0] cur;
            int n = 1;
            bit bad = 1'b0;
            wait_change();
            cur = dig_sel_n;
            if ($countones(~dig_sel_n) != 1) bad = 1'b1;
            @(negedge clk);
            while (dig_sel_n === cur && n < 100) begin
                n++;
                if ($countones(~dig_sel_n) != 1) bad = 1'b1;
                @(negedge clk);
            end
            check("R3 dwell cycles", 16'(n), 16'(DIV));
            check("R2 one common low", {15'h0, bad}, 16'h0000);
        end

        // R7: mid-dwell change ignored; change in last cycle before advance captured
        begin
            int x;
            int nx;
            logic [7:0] held;
            wait_change();
            x    = idx_of(dig_sel_n);
            nx   = (x + 1) % 4;
            held = seg_out;
            @(negedge clk);
            set_digit(x, 4'h5, ~dv[4*x]);
            repeat (DIV - 2) @(negedge clk);
            check("R7 mid-dwell change ignored", {8'h0, seg_out}, {8'h0, held});
            set_digit(nx, 4'hE, 1'b0);
            @(negedge clk);
            check("R7 new digit selected", {12'h0, dig_sel_n}, {12'h0, sel_of(nx)});
            check("R7 late change captured", {8'h0, seg_out}, {8'h0, exp_seg(4'hE, 1'b0)});
        end

        // R4: scan order over a full turn and wrap
        wait_for(0);
        for (int j = 1; j <= 5; j++) begin
            wait_change();
            check($sformatf("R4 order step %0d", j), {12'h0, dig_sel_n}, {12'h0, sel_of(j % 4)});
        end

        // R1 with tick in the same cycle, then R8 re-entry
        wait_change();
        repeat (DIV - 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset beats tick sel", {12'h0, dig_sel_n}, 16'h000F);
        check("R1 reset beats tick seg", {8'h0, seg_out}, 16'h0000);
        set_digit(0, 4'hA, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R8 re-entry sel", {12'h0, dig_sel_n}, 16'h000E);
        check("R8 re-entry seg", {8'h0, seg_out}, {8'h0, exp_seg(4'hA, 1'b1)});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule